// File: doc/BRIEF.md
# Flat-Priority Gated Interrupt Controller

This block gathers interrupt flags from a set of peripheral modules and decides when the CPU should be asked to take an interrupt. Every source has the same priority. When an interrupt is accepted, the CPU always branches to one address, held in a programmable vector register. A request only goes out when five things are true at once: the global enable is on, the source's module enable is on, the source's local enable is on, its flag is set, and no handler is in service.

Flags are sticky. A hardware pulse sets a flag, and it stays set until software writes it clear. A single register write port reaches all the configuration: the flag bytes, the local enable bytes, the module enable word, the control word and the vector register.

The CPU reports two events on strobes. One says that it has vectored to the handler, which sets the in-service bit. The other says that it has returned from the handler, which clears that bit. Software may also clear the in-service bit itself, so that a handler can be interrupted again (nesting).

Top module: `irq_gate_ctrl`

## Requirements
- R1: After a synchronous reset, all of the following are 0: every flag, every local enable, every module enable, the global enable, the in-service bit, `vector` (reset value 0000h), `pending` and `irq_req`.
- R2: `irq_req` is 1 exactly when at least one source has its flag, local enable and module enable all at 1, the global enable is 1, and the in-service bit is 0. `irq_req` is decoded combinationally from registered state, so it is valid in the cycle after the write or strobe that changes that state.
- R3: While a module's enable bit is 0, none of that module's sources can appear in `pending` or raise `irq_req`, whatever their local enables hold.
- R4: A local enable at 0 blocks its own source. At 1, its source requests whenever its flag is 1. A flag set by a software write counts the same as one set by hardware.
- R5: A `hw_set` pulse sets its flag. The flag stays at 1 over any number of idle cycles and over `vec_taken` and `irq_return` strobes. It is cleared only by a software flag write that has a 0 in that bit.
- R6: If a hardware set and a software flag write to the same module fall in the same cycle, the flag takes the written value ORed with the hardware set. A software clear therefore loses to a hardware set.
- R7: `vec_taken` sets the in-service bit for the next cycle, and `irq_return` clears it. When both strobes arrive in the same cycle, the bit is set.
- R8: A control write sets the in-service bit from bit 1 of the data. Such a write can clear the bit so that a handler can be nested. When a control write falls in the same cycle as either CPU strobe, the strobe wins.
- R9: `vector` always shows the vector register. Only a vector write changes that register.
- R10: `pending[m*N_SRC+s]` equals flag AND local enable AND module enable for source `s` of module `m`. It does not depend on the global enable or on the in-service bit.
- R11: Register write encoding, with `reg_wr`=1:
  - `reg_sel`=0 writes the flags of module `reg_mod` from `reg_wdata[N_SRC-1:0]`.
  - `reg_sel`=1 writes the local enables of module `reg_mod`.
  - `reg_sel`=2 writes the module enables from `reg_wdata[N_MOD-1:0]`.
  - `reg_sel`=3 writes the control word: bit 0 is the global enable and bit 1 is the in-service bit.
  - `reg_sel`=4 writes the vector register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_set | input | N_MOD*N_SRC | One-cycle hardware flag set pulses, index m*N_SRC+s |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register selector (see R11) |
| reg_mod | input | MOD_W | Module index for flag and local-enable writes |
| reg_wdata | input | VEC_W | Write data |
| vec_taken | input | 1 | CPU has vectored to the handler |
| irq_return | input | 1 | CPU has returned from the handler |
| irq_req | output | 1 | Interrupt request to the CPU |
| vector | output | VEC_W | Handler address |
| in_service | output | 1 | Handler currently in service |
| pending | output | N_MOD*N_SRC | Per-source gated pending map |

## Verification
Two pairs of functions can land in the same cycle. The first is a hardware flag set colliding with a software write to the same flag byte. The second is a CPU strobe colliding with a software write of the in-service bit, or with the opposite strobe. Each directed task drives both inputs in one cycle. For the flags, the outcome is judged from `pending`. For the in-service bit, it is judged from `in_service` and `irq_req` in the following cycle. The expected values come from the precedence rules in R6, R7 and R8.

// File: rtl/irq_pkg.sv
// Shared definitions for the gated interrupt controller.
// Assumes reg_sel is a 3-bit code; unused codes write nothing.
package irq_pkg;

    typedef enum logic [2:0] {
        SEL_FLAG  = 3'd0,
        SEL_LOCEN = 3'd1,
        SEL_MODEN = 3'd2,
        SEL_CTRL  = 3'd3,
        SEL_VEC   = 3'd4
    } reg_sel_e;

    localparam int CTRL_GLB_BIT = 0;
    localparam int CTRL_INS_BIT = 1;

endpackage

// File: rtl/irq_src_bank.sv
// Holds the flags and the local enables of one peripheral module, and
// produces that module's gated pending vector.
// Assumes hw_set bits are single-cycle pulses. Flags are sticky; a
// hardware set always wins over a software clear in the same cycle.
module irq_src_bank #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] hw_set,
    input  logic             flag_wr,
    input  logic             en_wr,
    input  logic [N_SRC-1:0] wdata,
    input  logic             mod_en,
    output logic [N_SRC-1:0] pend
);

    logic [N_SRC-1:0] flag_q;
    logic [N_SRC-1:0] loc_en_q;

    // Flag register: software write replaces, hardware set ORs on top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else if (flag_wr) begin
            flag_q <= wdata | hw_set;
        end else begin
            flag_q <= flag_q | hw_set;
        end
    end

    // Local enable register: loaded by software only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loc_en_q <= '0;
        end else if (en_wr) begin
            loc_en_q <= wdata;
        end
    end

    // Per-source gating by local and module enable.
    always_comb begin
        pend = flag_q & loc_en_q & {N_SRC{mod_en}};
    end

    AST_HW_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_set) |=> ((flag_q & $past(hw_set)) == $past(hw_set))); // R6
    AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_wr && (hw_set == '0)) |=> $stable(flag_q)); // R5

endmodule

// File: rtl/irq_svc_ctrl.sv
// Holds the module enables, the global enable, the in-service bit and
// the vector register.
// Assumes vec_taken and irq_return are single-cycle strobes from the CPU.
// CPU strobes take precedence over software writes of the in-service bit.
module irq_svc_ctrl #(
    parameter int N_MOD = 4,
    parameter int VEC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mod_wr,
    input  logic             ctrl_wr,
    input  logic             vec_wr,
    input  logic [VEC_W-1:0] wdata,
    input  logic             vec_taken,
    input  logic             irq_return,
    output logic [N_MOD-1:0] mod_en,
    output logic             glb_en,
    output logic             in_service,
    output logic [VEC_W-1:0] vector
);

    import irq_pkg::*;

    // Module enable word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_en <= '0;
        end else if (mod_wr) begin
            mod_en <= wdata[N_MOD-1:0];
        end
    end

    // Global enable from the control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glb_en <= 1'b0;
        end else if (ctrl_wr) begin
            glb_en <= wdata[CTRL_GLB_BIT];
        end
    end

    // In-service bit: vectoring sets it, return clears it, software last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_service <= 1'b0;
        end else if (vec_taken) begin
            in_service <= 1'b1;
        end else if (irq_return) begin
            in_service <= 1'b0;
        end else if (ctrl_wr) begin
            in_service <= wdata[CTRL_INS_BIT];
        end
    end

    // Vector register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vector <= '0;
        end else if (vec_wr) begin
            vector <= wdata;
        end
    end

    AST_INS_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_taken |=> in_service); // R7
    AST_INS_OFF_RET: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_return && !vec_taken) |=> !in_service); // R7
    AST_INS_SW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!vec_taken && !irq_return && !ctrl_wr) |=> $stable(in_service)); // R8
    AST_VEC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_wr |=> $stable(vector)); // R9

endmodule

// File: rtl/irq_gate_ctrl.sv
// Top of the flat-priority gated interrupt controller. It decodes the
// register write port, instantiates one source bank per module, and
// combines the banks' pending bits with the global enable and the
// in-service bit to form the request.
// Assumes VEC_W >= N_SRC, VEC_W >= N_MOD and VEC_W >= 2.
module irq_gate_ctrl #(
    parameter int N_MOD = 4,
    parameter int N_SRC = 8,
    parameter int VEC_W = 16,
    localparam int MOD_W = (N_MOD > 1) ? $clog2(N_MOD) : 1,
    localparam int N_ALL = N_MOD * N_SRC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_ALL-1:0] hw_set,
    input  logic             reg_wr,
    input  logic [2:0]       reg_sel,
    input  logic [MOD_W-1:0] reg_mod,
    input  logic [VEC_W-1:0] reg_wdata,
    input  logic             vec_taken,
    input  logic             irq_return,
    output logic             irq_req,
    output logic [VEC_W-1:0] vector,
    output logic             in_service,
    output logic [N_ALL-1:0] pending
);

    import irq_pkg::*;

    reg_sel_e         sel;
    logic [N_MOD-1:0] mod_en;
    logic             glb_en;
    logic             flag_sel;
    logic             len_sel;

    // Decode the register selector.
    always_comb begin
        sel      = reg_sel_e'(reg_sel);
        flag_sel = reg_wr && (sel == SEL_FLAG);
        len_sel  = reg_wr && (sel == SEL_LOCEN);
    end

    irq_svc_ctrl #(
        .N_MOD (N_MOD),
        .VEC_W (VEC_W)
    ) u_svc (
        .clk        (clk),
        .rst_n      (rst_n),
        .mod_wr     (reg_wr && (sel == SEL_MODEN)),
        .ctrl_wr    (reg_wr && (sel == SEL_CTRL)),
        .vec_wr     (reg_wr && (sel == SEL_VEC)),
        .wdata      (reg_wdata),
        .vec_taken  (vec_taken),
        .irq_return (irq_return),
        .mod_en     (mod_en),
        .glb_en     (glb_en),
        .in_service (in_service),
        .vector     (vector)
    );

    for (genvar m = 0; m < N_MOD; m++) begin : g_bank
        irq_src_bank #(
            .N_SRC (N_SRC)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .hw_set  (hw_set[m*N_SRC +: N_SRC]),
            .flag_wr (flag_sel && (reg_mod == MOD_W'(m))),
            .en_wr   (len_sel && (reg_mod == MOD_W'(m))),
            .wdata   (reg_wdata[N_SRC-1:0]),
            .mod_en  (mod_en[m]),
            .pend    (pending[m*N_SRC +: N_SRC])
        );

        AST_MOD_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
            !mod_en[m] |-> (pending[m*N_SRC +: N_SRC] == '0)); // R3
    end

    // Final request gate: global enable, no handler active, any pending.
    always_comb begin
        irq_req = glb_en && !in_service && (|pending);
    end

    AST_REQ_BLOCKED_IN_SVC: assert property (@(posedge clk) disable iff (!rst_n)
        in_service |-> !irq_req); // R2
    AST_REQ_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_taken |=> !irq_req); // R7

endmodule

// File: tb/irq_gate_ctrl_tb.sv
`timescale 1ns/1ps
// Directed bench for irq_gate_ctrl: one task per scenario.
module irq_gate_ctrl_tb;

    localparam int N_MOD = 4;
    localparam int N_SRC = 8;
    localparam int VEC_W = 16;
    localparam int N_ALL = N_MOD * N_SRC;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [N_ALL-1:0] hw_set;
    logic             reg_wr;
    logic [2:0]       reg_sel;
    logic [1:0]       reg_mod;
    logic [VEC_W-1:0] reg_wdata;
    logic             vec_taken;
    logic             irq_return;
    logic             irq_req;
    logic [VEC_W-1:0] vector;
    logic             in_service;
    logic [N_ALL-1:0] pending;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    irq_gate_ctrl #(.N_MOD(N_MOD), .N_SRC(N_SRC), .VEC_W(VEC_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .hw_set(hw_set), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .reg_mod(reg_mod), .reg_wdata(reg_wdata),
        .vec_taken(vec_taken), .irq_return(irq_return), .irq_req(irq_req),
        .vector(vector), .in_service(in_service), .pending(pending)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        hw_set = '0; reg_wr = 0; reg_sel = 0; reg_mod = 0; reg_wdata = '0;
        vec_taken = 0; irq_return = 0;
    endtask

    task automatic set_wr(input logic [2:0] s, input logic [1:0] m, input logic [15:0] d);
        reg_wr = 1; reg_sel = s; reg_mod = m; reg_wdata = d;
    endtask

    task automatic wr(input logic [2:0] s, input logic [1:0] m, input logic [15:0] d);
        set_wr(s, m, d);
        tick();
        idle();
    endtask

    task automatic hw_pulse(input logic [N_ALL-1:0] bits);
        hw_set = bits;
        tick();
        idle();
    endtask

    task automatic do_reset();
        idle();
        rst_n = 0;
        tick(); tick();
        rst_n = 1;
    endtask

    // R1: reset state
    task automatic t_reset();
        do_reset();
        chk("R1 irq_req", {31'd0, irq_req}, 32'd0);
        chk("R1 in_service", {31'd0, in_service}, 32'd0);
        chk("R1 vector", {16'd0, vector}, 32'h0000);
        chk("R1 pending", pending, 32'd0);
        wr(3'd2, 2'd0, 16'h000F);
        wr(3'd3, 2'd0, 16'h0001);
        chk("R1 no flags after enables", pending, 32'd0);
        chk("R1 no request", {31'd0, irq_req}, 32'd0);
    endtask

    // R2, R11: five-way gate
    task automatic t_gate();
        do_reset();
        wr(3'd3, 2'd0, 16'h0001);
        wr(3'd2, 2'd0, 16'h0001);
        wr(3'd1, 2'd0, 16'h0001);
        chk("R2 no flag no req", {31'd0, irq_req}, 32'd0);
        hw_pulse(32'h1);
        chk("R2 all gates open", {31'd0, irq_req}, 32'd1);
        wr(3'd3, 2'd0, 16'h0000);
        chk("R2 global off", {31'd0, irq_req}, 32'd0);
        wr(3'd3, 2'd0, 16'h0001);
        chk("R2 global back on", {31'd0, irq_req}, 32'd1);
        wr(3'd0, 2'd0, 16'h0000);
        chk("R2 flag cleared", {31'd0, irq_req}, 32'd0);
    endtask

    // R3: module enable blocks the whole module
    task automatic t_module();
        do_reset();
        wr(3'd3, 2'd0, 16'h0001);
        wr(3'd1, 2'd1, 16'h00FF);
        wr(3'd2, 2'd0, 16'h0001);
        hw_pulse(32'h0000_FF00);
        chk("R3 module1 blocked pending", pending, 32'd0);
        chk("R3 module1 blocked req", {31'd0, irq_req}, 32'd0);
        wr(3'd2, 2'd0, 16'h0002);
        chk("R3 module1 open", pending, 32'h0000_FF00);
        chk("R3 module1 req", {31'd0, irq_req}, 32'd1);
    endtask

    // R4: local enable, software-set flag
    task automatic t_local();
        do_reset();
        wr(3'd3, 2'd0, 16'h0001);
        wr(3'd2, 2'd0, 16'h0004);
        wr(3'd0, 2'd2, 16'h0010);
        chk("R4 local off", {31'd0, irq_req}, 32'd0);
        wr(3'd1, 2'd2, 16'h0010);
        chk("R4 sw flag pending", pending, 32'h0010_0000);
        chk("R4 sw flag req", {31'd0, irq_req}, 32'd1);
        wr(3'd1, 2'd2, 16'h0020);
        chk("R4 other local only", {31'd0, irq_req}, 32'd0);
    endtask

    // R5, R10: sticky flags, strobes do not clear them
    task automatic t_sticky();
        do_reset();
        wr(3'd2, 2'd0, 16'h0001);
        wr(3'd1, 2'd0, 16'h00FF);
        hw_pulse(32'h20);
        tick(); tick(); tick();
        chk("R10 pending w/o global", pending, 32'h20);
        chk("R5 held after idle", pending, 32'h20);
        wr(3'd3, 2'd0, 16'h0001);
        vec_taken = 1; tick(); idle();
        chk("R5 held over vec_taken", pending, 32'h20);
        chk("R10 pending while in service", pending, 32'h20);
        irq_return = 1; tick(); idle();
        chk("R5 held over return", pending, 32'h20);
        chk("R5 req again", {31'd0, irq_req}, 32'd1);
        wr(3'd0, 2'd0, 16'h0000);
        chk("R5 sw clear", pending, 32'd0);
    endtask

    // R6: hardware set vs software write
    task automatic t_collide();
        do_reset();
        wr(3'd2, 2'd0, 16'h0008);
        wr(3'd1, 2'd3, 16'h00FF);
        hw_pulse(32'h0300_0000);
        chk("R6 setup", pending, 32'h0300_0000);
        set_wr(3'd0, 2'd3, 16'h0000);
        hw_set = 32'h0200_0000;
        tick(); idle();
        chk("R6 hw beats sw clear", pending, 32'h0200_0000);
        set_wr(3'd0, 2'd3, 16'h0004);
        hw_set = 32'h0100_0000;
        tick(); idle();
        chk("R6 write ORed with hw", pending, 32'h0500_0000);
    endtask

    // R7, R8: in-service precedence
    task automatic t_service();
        do_reset();
        wr(3'd3, 2'd0, 16'h0001);
        wr(3'd2, 2'd0, 16'h0001);
        wr(3'd1, 2'd0, 16'h0001);
        hw_pulse(32'h1);
        vec_taken = 1; tick(); idle();
        chk("R7 taken sets", {31'd0, in_service}, 32'd1);
        chk("R7 req masked", {31'd0, irq_req}, 32'd0);
        vec_taken = 1; irq_return = 1; tick(); idle();
        chk("R7 both strobes set", {31'd0, in_service}, 32'd1);
        irq_return = 1; tick(); idle();
        chk("R7 return clears", {31'd0, in_service}, 32'd0);
        chk("R7 req back", {31'd0, irq_req}, 32'd1);
        vec_taken = 1; tick(); idle();
        wr(3'd3, 2'd0, 16'h0001);
        chk("R8 sw clear nests", {31'd0, in_service}, 32'd0);
        chk("R8 req after sw clear", {31'd0, irq_req}, 32'd1);
        wr(3'd3, 2'd0, 16'h0003);
        chk("R8 sw set", {31'd0, in_service}, 32'd1);
        set_wr(3'd3, 2'd0, 16'h0001); irq_return = 0; vec_taken = 1;
        tick(); idle();
        chk("R8 taken beats sw clear", {31'd0, in_service}, 32'd1);
        set_wr(3'd3, 2'd0, 16'h0003); irq_return = 1;
        tick(); idle();
        chk("R8 return beats sw set", {31'd0, in_service}, 32'd0);
    endtask

    // R9: vector register
    task automatic t_vector();
        do_reset();
        chk("R9 reset vector", {16'd0, vector}, 32'h0000);
        wr(3'd4, 2'd0, 16'hABCD);
        chk("R9 written", {16'd0, vector}, 32'hABCD);
        wr(3'd3, 2'd0, 16'h1235);
        wr(3'd0, 2'd1, 16'h0055);
        chk("R9 other writes ignored", {16'd0, vector}, 32'hABCD);
    endtask

    initial begin
        rst_n = 0;
        idle();
        t_reset();
        t_gate();
        t_module();
        t_local();
        t_sticky();
        t_collide();
        t_service();
        t_vector();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule